// File: doc/BRIEF.md
# Maskable Repeating Alarm Comparator

This block stores an alarm time made of four byte registers (seconds, minutes, hours, day of month) and checks it against the running BCD calendar time whenever a one-second strobe arrives. When the check succeeds, it raises a single-cycle interrupt pulse. The top bit of each alarm register is a "don't care" flag. The combination of these flags sets the repeat interval of the alarm: monthly, daily, hourly, every minute or every second.

A fifth register holds a free byte for interrupt control. A host reaches all five registers through a simple synchronous write port and a combinational read port. The timekeeping counters sit outside the block. They supply the current time fields, the one-second strobe and a stop flag that pauses the clock.

Top module: `alarm_cmp`

## Requirements
- R1: After reset, every register reads 0x00 and `irq_o` is low.
- R2: Register addresses are 0 for alarm seconds, 1 for alarm minutes, 2 for alarm hours, 3 for alarm day and 4 for control. An accepted write stores the whole byte, bit 7 (the don't-care flag) included, and a read returns it. The compared fields are bits 6:0 for seconds and minutes, bits 5:0 for hours and bits 4:0 for the day.
- R3: A write to an alarm register is dropped if its field, read as BCD, is out of range. The limits are: seconds or minutes above 59, hours above 23, or a day field equal to zero.
- R4: When all four flags are clear, a strobe raises the interrupt only if day, hours, minutes and seconds all match.
- R5: When only the day flag is set, hours, minutes and seconds must match. This gives a daily alarm.
- R6: When the day and hour flags are set and the others are clear, minutes and seconds must match. This gives an hourly alarm.
- R7: When the day, hour and minute flags are set and the seconds flag is clear, only seconds must match. This gives an alarm every minute.
- R8: Any other flag combination raises the interrupt on every strobe.
- R9: The interrupt is a pulse one clock long. It appears in the cycle after the strobe, and the check uses the time presented in the strobe cycle.
- R10: Without a strobe, no interrupt is raised, even if the time matches.
- R11: While `stop_i` is high, strobes cause no interrupt.
- R12: The control register is a plain read/write byte with no effect on the interrupt. Addresses 5 to 7 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| stop_i | input | 1 | Clock stopped; suppresses comparison |
| now_sec_i | input | 8 | Current seconds, BCD |
| now_min_i | input | 8 | Current minutes, BCD |
| now_hour_i | input | 8 | Current hours, BCD |
| now_day_i | input | 8 | Current day of month, BCD |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | Alarm interrupt pulse |

## Verification
A wrong stored alarm byte shows up on `rdata_o` in the same cycle it is addressed. A wrong flag decode or field comparison shows up on `irq_o` one clock after the next strobe, as a missing pulse or an extra one. A pulse that is held too long shows up in the second cycle after the strobe. For that reason each scenario pairs a matching strobe with a strobe that differs in exactly the field the active mode still compares.

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          stop_i,
  input  logic [DW-1:0] now_sec_i,
  input  logic [DW-1:0] now_min_i,
  input  logic [DW-1:0] now_hour_i,
  input  logic [DW-1:0] now_day_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);

  localparam logic [AW-1:0] A_SEC  = AW'(0);
  localparam logic [AW-1:0] A_MIN  = AW'(1);
  localparam logic [AW-1:0] A_HOUR = AW'(2);
  localparam logic [AW-1:0] A_DAY  = AW'(3);
  localparam logic [AW-1:0] A_CTL  = AW'(4);
  localparam int MSB = DW - 1;

  typedef enum logic [2:0] {RPT_MONTH, RPT_DAY, RPT_HOUR, RPT_MIN, RPT_SEC} rpt_e;

  logic [DW-1:0] al_sec, al_min, al_hour, al_day, ctl;
  logic          sec_ok, min_ok, hour_ok, day_ok;
  logic          eq_s, eq_m, eq_h, eq_d, hit;
  rpt_e          rpt;

  function automatic logic [6:0] bcd2bin(input logic [6:0] b);
    return 7'(b[6:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  assign sec_ok  = bcd2bin(wdata_i[6:0]) <= 7'd59;
  assign min_ok  = sec_ok;
  assign hour_ok = bcd2bin({1'b0, wdata_i[5:0]}) <= 7'd23;
  assign day_ok  = wdata_i[4:0] != 5'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al_sec  <= '0;
      al_min  <= '0;
      al_hour <= '0;
      al_day  <= '0;
      ctl     <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_SEC:  if (sec_ok)  al_sec  <= wdata_i;
        A_MIN:  if (min_ok)  al_min  <= wdata_i;
        A_HOUR: if (hour_ok) al_hour <= wdata_i;
        A_DAY:  if (day_ok)  al_day  <= wdata_i;
        A_CTL:  ctl <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      A_SEC:   rdata_o = al_sec;
      A_MIN:   rdata_o = al_min;
      A_HOUR:  rdata_o = al_hour;
      A_DAY:   rdata_o = al_day;
      A_CTL:   rdata_o = ctl;
      default: rdata_o = '0;
    endcase
  end

  assign eq_s = al_sec[6:0]  == now_sec_i[6:0];
  assign eq_m = al_min[6:0]  == now_min_i[6:0];
  assign eq_h = al_hour[5:0] == now_hour_i[5:0];
  assign eq_d = al_day[4:0]  == now_day_i[4:0];

  always_comb begin
    case ({al_day[MSB], al_hour[MSB], al_min[MSB], al_sec[MSB]})
      4'b0000: rpt = RPT_MONTH;
      4'b1000: rpt = RPT_DAY;
      4'b1100: rpt = RPT_HOUR;
      4'b1110: rpt = RPT_MIN;
      default: rpt = RPT_SEC;
    endcase
  end

  always_comb begin
    case (rpt)
      RPT_MONTH: hit = eq_d & eq_h & eq_m & eq_s;
      RPT_DAY:   hit = eq_h & eq_m & eq_s;
      RPT_HOUR:  hit = eq_m & eq_s;
      RPT_MIN:   hit = eq_s;
      default:   hit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= tick_i & ~stop_i & hit;
  end

  // R9 / R10: a pulse needs a strobe in the previous cycle
  a_r10_irq_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(tick_i));
  a_r11_stop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !irq_o);
  a_r8_every_second: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !stop_i && rpt == RPT_SEC) |=> irq_o);
  a_r4_month_needs_day: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && rpt == RPT_MONTH && !eq_d) |=> !irq_o);
  a_r3_bad_sec_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == A_SEC && bcd2bin(wdata_i[6:0]) > 7'd59) |=> $stable(al_sec));
  a_r12_ctl_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == A_CTL) |=> (ctl == $past(wdata_i)));

endmodule

// File: tb/alarm_cmp_bench.sv
module alarm_cmp_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, stop_i = 1'b0, wr_en_i = 1'b0;
  logic [7:0] now_sec_i = '0, now_min_i = '0, now_hour_i = '0, now_day_i = '0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_cmp u_alarm_cmp (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr_i = a;
    #1 chk(req, rdata_o, exp);
  endtask

  task automatic strobe(input string req, input logic [7:0] d, input logic [7:0] h,
                        input logic [7:0] m, input logic [7:0] s, input logic exp);
    @(negedge clk);
    now_day_i = d; now_hour_i = h; now_min_i = m; now_sec_i = s; tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    chk(req, {7'd0, irq_o}, {7'd0, exp});
    @(negedge clk);
    chk("R9 pulse width", {7'd0, irq_o}, 8'd0);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 5; a++) rd("R1", 3'(a), 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'd0);
  endtask

  task automatic t_month;
    wr(3'd0, 8'h30); wr(3'd1, 8'h15); wr(3'd2, 8'h12); wr(3'd3, 8'h21);
    rd("R2 sec", 3'd0, 8'h30); rd("R2 min", 3'd1, 8'h15);
    rd("R2 hour", 3'd2, 8'h12); rd("R2 day", 3'd3, 8'h21);
    wr(3'd0, 8'h60); rd("R3 sec", 3'd0, 8'h30);
    wr(3'd1, 8'h5A); rd("R3 min", 3'd1, 8'h15);
    wr(3'd2, 8'h24); rd("R3 hour", 3'd2, 8'h12);
    wr(3'd3, 8'h00); rd("R3 day", 3'd3, 8'h21);
    wr(3'd3, 8'h20); rd("R3 day field", 3'd3, 8'h21);
    strobe("R4 match", 8'h21, 8'h12, 8'h15, 8'h30, 1'b1);
    strobe("R4 day differs", 8'h22, 8'h12, 8'h15, 8'h30, 1'b0);
  endtask

  task automatic t_notick;
    @(negedge clk);
    now_day_i = 8'h21; now_hour_i = 8'h12; now_min_i = 8'h15; now_sec_i = 8'h30;
    repeat (4) begin
      @(negedge clk);
      chk("R10 no strobe", {7'd0, irq_o}, 8'd0);
    end
  endtask

  task automatic t_day;
    wr(3'd3, 8'hA1); rd("R2 flag kept", 3'd3, 8'hA1);
    strobe("R5 daily", 8'h05, 8'h12, 8'h15, 8'h30, 1'b1);
    strobe("R5 hour differs", 8'h05, 8'h13, 8'h15, 8'h30, 1'b0);
  endtask

  task automatic t_hour;
    wr(3'd2, 8'h92);
    strobe("R6 hourly", 8'h07, 8'h03, 8'h15, 8'h30, 1'b1);
    strobe("R6 min differs", 8'h07, 8'h03, 8'h16, 8'h30, 1'b0);
  endtask

  task automatic t_minute;
    wr(3'd1, 8'h95);
    strobe("R7 minute", 8'h07, 8'h03, 8'h44, 8'h30, 1'b1);
    strobe("R7 sec differs", 8'h07, 8'h03, 8'h44, 8'h31, 1'b0);
  endtask

  task automatic t_second;
    wr(3'd0, 8'hB0);
    strobe("R8 all flags", 8'h09, 8'h01, 8'h02, 8'h03, 1'b1);
    wr(3'd3, 8'h21); wr(3'd2, 8'h12); wr(3'd1, 8'h15);
    strobe("R8 sec flag only", 8'h01, 8'h01, 8'h01, 8'h01, 1'b1);
  endtask

  task automatic t_stop;
    @(negedge clk); stop_i = 1'b1;
    strobe("R11 stopped", 8'h01, 8'h01, 8'h01, 8'h01, 1'b0);
    @(negedge clk); stop_i = 1'b0;
  endtask

  task automatic t_ctl;
    wr(3'd4, 8'h5A); rd("R12 ctl", 3'd4, 8'h5A);
    wr(3'd6, 8'hFF); rd("R12 unused", 3'd6, 8'h00);
    rd("R12 ctl intact", 3'd4, 8'h5A);
    wr(3'd0, 8'h30);
    strobe("R12 ctl no effect", 8'h21, 8'h12, 8'h15, 8'h30, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_month(); t_notick(); t_day(); t_hour();
    t_minute(); t_second(); t_stop(); t_ctl();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule